// File: doc/BRIEF.md
# Clock Synthesizer Serial Word Transmitter

This block loads one 24-bit control word into an external programmable clock synthesizer over a two-wire serial link made of a clock line and a data line. A single start strobe latches the word and the pin-step length. The block then plays out a fixed frame on the two lines: a wake-up run, a start marker, the 24 data bits, and a stop marker. It then holds the lines idle for a settle interval before it reports completion. The synthesizer cannot be read back, so the frame is sent blind.

The word is sent least significant bit first. Its top three bits (23:21) select the target register inside the synthesizer; value 2 selects the video clock register. The lower 21 bits carry the divider setting. Each data bit takes four line states. The complement of the bit is presented before its true value, so the receiver can reject glitches. Each line state is held for a run-time number of system clock cycles. The settle interval is a cycle-count parameter.

Top module: `synth_word_tx`

## Requirements
- R1: After reset, and while idle, sclk_o and sdat_o are both 1, busy_o is 0 and done_o is 0.
- R2: The frame opens with 12 line states. sdat_o stays at 1 while sclk_o alternates 0,1,0,1,… beginning at 0, which gives one rising step followed by five full low-high pulses.
- R3: Five states follow the opening run, as (sclk_o, sdat_o): (0,1), (0,0), (1,0), (0,0), (1,0).
- R4: Each data bit b then takes four states: (1,~b), (0,~b), (0,b), (1,b).
- R5: The 24 bits of the latched word are sent least significant bit first. Bits 23:21 (register select) therefore go out last. Reading sdat_o in the fourth state of each bit group gives back the word.
- R6: The frame closes with (1,1), (0,1), (1,1). The lines then stay at (1,1).
- R7: Each line state lasts exactly step_len_i cycles, and a value of 0 counts as 1. step_len_i is captured on the start cycle, so later changes to it have no effect on the frame in progress.
- R8: busy_o rises in the cycle after start_i is accepted. After the last frame state, the lines rest at (1,1) for SETTLE_CYC cycles with busy_o still high. done_o then pulses high for exactly one cycle in the same cycle that busy_o falls. The total busy time is 116·L + SETTLE_CYC cycles, where L is the effective step length.
- R9: The block ignores start_i while busy_o is high, and it captures word_i only on the start cycle. A strobe or a word change during a transfer changes neither the frame nor the completion timing, and it does not trigger a second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| word_i | input | WORD_W | Control word: select in 23:21, divider below |
| step_len_i | input | STEP_W | Cycles per line state (0 counts as 1) |
| busy_o | output | 1 | Transfer or settle in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Serial clock line to the synthesizer |
| sdat_o | output | 1 | Serial data line to the synthesizer |

## Verification
Two events can fall in the same cycle: a new start strobe and a frame that is already in progress. In selected runs, the bench pulses start_i and changes word_i and step_len_i while the data bits are going out. It then decodes the line waveform state by state against a frame built from the requirements. The run passes only if the decoded word, the per-state hold length, the settle length and the single done pulse all still match the original request, and busy_o stays low after completion.

// File: rtl/synth_tx_pkg.sv
package synth_tx_pkg;
  localparam int PRE_STATES   = 12;
  localparam int START_STATES = 5;
  localparam int BIT_PHASES   = 4;
  localparam int STOP_STATES  = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_SETTLE} tx_state_e;

  typedef struct packed {
    logic sclk;
    logic sdat;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sclk: 1'b1, sdat: 1'b1};
endpackage

// File: rtl/synth_tx_step_timer.sv
module synth_tx_step_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] len_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == len_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/synth_tx_settle.sv
module synth_tx_settle #(
  parameter int CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == CW'(CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (done_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/synth_tx_pattern.sv
module synth_tx_pattern
  import synth_tx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int IDX_W  = 7
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] word_i,
  output pins_t             pins_o
);
  localparam int BIT_BASE  = PRE_STATES + START_STATES;
  localparam int STOP_BASE = BIT_BASE + BIT_PHASES * WORD_W;

  always_comb begin
    int ii, j, ph;
    logic b;
    ii = int'({1'b0, idx_i});
    j  = 0;
    ph = 0;
    b  = 1'b0;
    pins_o = PINS_IDLE;
    if (ii < PRE_STATES) begin
      pins_o.sclk = idx_i[0];
      pins_o.sdat = 1'b1;
    end else if (ii < BIT_BASE) begin
      j = ii - PRE_STATES;
      pins_o.sclk = (j == 2) || (j == 4);
      pins_o.sdat = (j == 0);
    end else if (ii < STOP_BASE) begin
      j  = ii - BIT_BASE;
      ph = j % BIT_PHASES;
      for (int i = 0; i < WORD_W; i++)
        if (j / BIT_PHASES == i) b = word_i[i];
      // complement in phases 0/1, true value in 2/3
      pins_o.sclk = (ph == 0) || (ph == 3);
      pins_o.sdat = (ph >= 2) ? b : ~b;
    end else begin
      j = ii - STOP_BASE;
      pins_o.sclk = (j != 1);
      pins_o.sdat = 1'b1;
    end
  end
endmodule

// File: rtl/synth_word_tx.sv
module synth_word_tx
  import synth_tx_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int STEP_W     = 8,
  parameter int SETTLE_CYC = 2500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [STEP_W-1:0] step_len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              sdat_o
);
  localparam int N_STATES = PRE_STATES + START_STATES + BIT_PHASES * WORD_W + STOP_STATES;
  localparam int IDX_W    = $clog2(N_STATES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_STATES - 1);

  tx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] word_q;
  logic [STEP_W-1:0] len_q;
  logic              done_q;
  logic              tick, settle_done;
  pins_t             frame_pins, pins;

  synth_tx_step_timer #(.W(STEP_W)) u_step (
    .clk_i, .rst_ni,
    .en_i  (state_q == ST_SEND),
    .len_i (len_q),
    .tick_o(tick)
  );

  synth_tx_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk_i, .rst_ni,
    .en_i  (state_q == ST_SETTLE),
    .done_o(settle_done)
  );

  synth_tx_pattern #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_pat (
    .idx_i (idx_q),
    .word_i(word_q),
    .pins_o(frame_pins)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      word_q  <= '0;
      len_q   <= STEP_W'(1);
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SEND;
          idx_q   <= '0;
          word_q  <= word_i;
          len_q   <= (step_len_i == '0) ? STEP_W'(1) : step_len_i;
        end
        ST_SEND: if (tick) begin
          if (idx_q == LAST_IDX) state_q <= ST_SETTLE;
          else                   idx_q   <= idx_q + IDX_W'(1);
        end
        ST_SETTLE: if (settle_done) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pins   = (state_q == ST_SEND) ? frame_pins : PINS_IDLE;
  assign sclk_o = pins.sclk;
  assign sdat_o = pins.sdat;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/synth_word_tx_chk.sv
module synth_word_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic sdat_o
);
  // R1
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sclk_o && sdat_o));

  // R2
  frame_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!sclk_o && sdat_o));

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R9
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind synth_word_tx synth_word_tx_chk chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .sclk_o (sclk_o),
  .sdat_o (sdat_o)
);

// File: tb/synth_word_tx_tb_top.sv
`timescale 1ns/1ps
module synth_word_tx_tb_top;
  localparam int WORD_W = 24;
  localparam int STEP_W = 4;
  localparam int SETTLE = 20;
  localparam int NST    = 116;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [WORD_W-1:0] word_i = '0;
  logic [STEP_W-1:0] step_len_i = '0;
  logic busy_o, done_o, sclk_o, sdat_o;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit finished = 0;

  logic exp_c [NST];
  logic exp_d [NST];
  logic rec_c [NST];
  logic rec_d [NST];

  always #4 clk = ~clk;

  synth_word_tx #(.WORD_W(WORD_W), .STEP_W(STEP_W), .SETTLE_CYC(SETTLE)) dut_i (
    .clk_i(clk), .rst_ni, .start_i, .word_i, .step_len_i,
    .busy_o, .done_o, .sclk_o, .sdat_o
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      miscompares++;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, 150000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  int n;
  task automatic push(input logic c, input logic d);
    exp_c[n] = c; exp_d[n] = d; n++;
  endtask

  task automatic build(input logic [WORD_W-1:0] w);
    n = 0;
    push(0, 1); push(1, 1);
    for (int p = 0; p < 5; p++) begin push(0, 1); push(1, 1); end
    push(0, 1); push(0, 0); push(1, 0); push(0, 0); push(1, 0);
    for (int i = 0; i < WORD_W; i++) begin
      push(1, ~w[i]); push(0, ~w[i]); push(0, w[i]); push(1, w[i]);
    end
    push(1, 1); push(0, 1); push(1, 1);
  endtask

  function automatic string region(input int k);
    if (k < 12) return "R2";
    if (k < 17) return "R3";
    if (k < 113) return "R4";
    return "R6";
  endfunction

  task automatic run(input logic [WORD_W-1:0] w, input logic [STEP_W-1:0] l, input bit inject);
    int eff;
    logic [WORD_W-1:0] dec;
    eff = (l == 0) ? 1 : int'(l);
    build(w);
    @(negedge clk);
    start_i = 1; word_i = w; step_len_i = l;
    @(negedge clk);
    start_i = 0; word_i = ~w; step_len_i = ~l;  // R9/R7: must not matter
    chk(busy_o == 1, "R8 busy rise", busy_o, 1);
    for (int k = 0; k < NST; k++) begin
      for (int c = 0; c < eff; c++) begin
        if (c == 0) begin
          rec_c[k] = sclk_o; rec_d[k] = sdat_o;
        end else begin
          chk({sclk_o, sdat_o} == {rec_c[k], rec_d[k]}, "R7 hold", {sclk_o, sdat_o}, {rec_c[k], rec_d[k]});
        end
        if (!busy_o) chk(0, "R8 busy during frame", busy_o, 1);
        start_i = inject && (k == 40) && (c == 0);  // R9 strobe mid-frame
        if (inject && k == 40) word_i = w ^ 24'h5a5a5a;
        @(negedge clk);
      end
    end
    start_i = 0;
    for (int k = 0; k < NST; k++)
      chk({rec_c[k], rec_d[k]} == {exp_c[k], exp_d[k]}, region(k), {rec_c[k], rec_d[k]}, {exp_c[k], exp_d[k]});
    for (int i = 0; i < WORD_W; i++) dec[i] = rec_d[17 + 4 * i + 3];
    chk(dec == w, "R5 decoded word", dec, w);
    for (int s = 0; s < SETTLE; s++) begin
      chk({sclk_o, sdat_o, busy_o, done_o} == 4'b1110, "R8 settle", {sclk_o, sdat_o, busy_o, done_o}, 4'b1110);
      @(negedge clk);
    end
    chk({busy_o, done_o} == 2'b01, "R8 done pulse", {busy_o, done_o}, 2'b01);
    @(negedge clk);
    chk({busy_o, done_o, sclk_o, sdat_o} == 4'b0011, "R6 R9 idle after", {busy_o, done_o, sclk_o, sdat_o}, 4'b0011);
    @(negedge clk);
    chk(busy_o == 0, "R9 no retrigger", busy_o, 0);
  endtask

  logic [WORD_W-1:0] words [8];
  logic [STEP_W-1:0] lens [5];

  initial begin
    words[0] = 24'h000000; words[1] = 24'hffffff; words[2] = 24'ha5a5a5; words[3] = 24'h5a5a5a;
    words[4] = 24'h412345; words[5] = 24'h000001; words[6] = 24'h800000; words[7] = 24'h123456;
    lens[0] = 1; lens[1] = 2; lens[2] = 3; lens[3] = 0; lens[4] = 15;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({sclk_o, sdat_o, busy_o, done_o} == 4'b1100, "R1 in reset", {sclk_o, sdat_o, busy_o, done_o}, 4'b1100);
    rst_ni = 1;
    @(negedge clk);
    chk({sclk_o, sdat_o, busy_o, done_o} == 4'b1100, "R1 after reset", {sclk_o, sdat_o, busy_o, done_o}, 4'b1100);
    for (int wi = 0; wi < 8; wi++)
      for (int li = 0; li < 5; li++)
        run(words[wi], lens[li], 1'b0);
    run(24'h4abcde, 4'd2, 1'b1);
    run(24'h0f0f0f, 4'd0, 1'b1);
    summary();
  end
endmodule